// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Critical-Word-First Refill

This block is a read-only instruction cache placed between a processor's fetch port and a Wishbone bus master that reaches a single-ported memory. The fetch side holds a request strobe and a byte address until the cache answers with a one-cycle ready pulse and the instruction word. Storage is direct-mapped: one tag entry and eight 32-bit words per line, with 64 lines (2 KB) by default.

The cache keeps the tag of the line it last looked up in a register. When a fetch moves to another line index, one cycle is spent reading the tag store before the cache can decide between hit and miss. On a miss, a wrapping 8-beat burst refills the line, starting with the word that missed. That word goes straight to the fetch port in the cycle its acknowledge arrives. Per-word valid flags let later fetches into the same line complete as their words land. The tag becomes valid only once the eighth word has been written.

An invalidate input clears every line over consecutive cycles, one line per cycle. Fetches wait while the sweep runs.

Top module: `fetch_icache`

## Requirements
- R1: A fetch to a resident line whose index equals the previously looked-up index is answered with fetchReady in the same cycle, with the memory word at the address (bits 1:0 of the address are ignored).
- R2: A fetch to a resident line with a different index than the previous lookup is answered in its second cycle.
- R3: On a miss the burst starts in the next cycle, with wbAdr at the missed word. CYC and STB stay high for the whole burst, and each ACK advances address bits 4:2 by one modulo 8 while bits above 4 hold (a miss at word 4 fetches 4,5,6,7,0,1,2,3).
- R4: Each burst has exactly 8 beats. wbCti is 3'b010 on beats 1 to 7 and 3'b111 on beat 8, and wbBte is 2'b10 throughout.
- R5: The missed word is returned on fetchReady in the same cycle as its ACK.
- R6: During a refill, a fetch to an already-arrived word of the filling line completes in one cycle. A fetch to a not-yet-arrived word stalls until the cycle its ACK arrives.
- R7: During a refill, a fetch to any other line gets no fetchReady until the burst has ended.
- R8: After all 8 words arrive, every word of the line hits with no bus activity.
- R9: A one-cycle flushReq pulse starts a sweep that clears all lines, one per cycle, after one cycle of latency. Fetches stall during the sweep, and afterwards a previously cached address misses. With default sizes and an immediate ACK, a fetch issued the cycle after the pulse completes in 64+3 cycles.
- R10: Under reset and after it, wbCyc, wbStb and fetchReady are low. The tag of the first lookup is treated as invalid.
- R11: The address splits into word bits 4:2, index bits 5+INDEX_W-1:5 and tag bits above the index. Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchReq | input | 1 | Fetch request, held until fetchReady |
| fetchAddr | input | ADDR_W | Fetch byte address |
| fetchReady | output | 1 | Fetch completes this cycle |
| fetchData | output | 32 | Instruction word, valid with fetchReady |
| flushReq | input | 1 | Invalidate all lines |
| wbCyc | output | 1 | Bus cycle |
| wbStb | output | 1 | Bus strobe |
| wbAdr | output | ADDR_W | Bus byte address of the current beat |
| wbCti | output | 3 | Cycle type identifier |
| wbBte | output | 2 | Burst type extension |
| wbAck | input | 1 | Beat acknowledge |
| wbDatIn | input | 32 | Read data of the beat |

## Verification
The bench counts cycles for each kind of access to catch off-by-one timing. A design without the bypass would return the missed word one cycle late. A design that skips the tag read on an index change would answer a line change in one cycle with stale tags. Fetches inside a half-filled line are aimed at both arrived and missing words, so a design that trusted the tag alone would return garbage or stall forever. With ACK held low, fetches to the filling line and to other lines are checked to stay unanswered. The start word and order of every burst are followed, so a counter that did not wrap within the line would leave the line. Aliasing tags and a sweep followed by a re-fetch expose stale-hit errors.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;
  localparam int DATA_W     = 32;
  localparam int OFFS_W     = 3;   // wrap-8 line: 8 words
  localparam int LINE_LO    = 5;   // first index bit
  localparam logic [2:0] CTI_INCR = 3'b010;
  localparam logic [2:0] CTI_END  = 3'b111;
  localparam logic [1:0] BTE_WRAP8 = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SWEEP} cacheState_e;

  typedef struct packed {
    logic loadLine;   // read tag store for a new index
    logic startFill;  // latch miss and open burst
    logic beatAck;    // one word arrived
    logic sweepStep;  // clear one line
    logic sweepEnd;   // sweep finished
    logic useBypass;  // forward bus data to fetch port
  } ctrlStrobes_t;
endpackage

// File: rtl/icache_datapath.sv
`timescale 1ns/1ps
module icache_datapath
  import icache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        ctrl,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic [DATA_W-1:0]   wbDatIn,
  output logic                lineSame,
  output logic                lineHit,
  output logic                fillLine,
  output logic                fillWordValid,
  output logic                ackWord,
  output logic                lastBeat,
  output logic                sweepLast,
  output logic [DATA_W-1:0]   fetchData,
  output logic [ADDR_W-1:0]   wbAdr,
  output logic [2:0]          wbCti
);
  localparam int TAG_W = ADDR_W - INDEX_W - LINE_LO;
  localparam int LINES = 1 << INDEX_W;
  localparam int WORDS = LINES << OFFS_W;

  logic [TAG_W-1:0]   tagRam [LINES];
  logic [DATA_W-1:0]  dataRam [WORDS];
  logic [LINES-1:0]   lineValid;

  logic [INDEX_W-1:0] curIndex;   // also the index of the line being filled
  logic [TAG_W-1:0]   curTag;
  logic               curValid;
  logic [TAG_W-1:0]   fillTag;
  logic [OFFS_W-1:0]  offsetCnt;
  logic [OFFS_W-1:0]  beatCnt;
  logic [7:0]         wordValid;
  logic [INDEX_W-1:0] sweepCnt;

  logic [TAG_W-1:0]   reqTag;
  logic [INDEX_W-1:0] reqIndex;
  logic [OFFS_W-1:0]  reqWord;
  logic               unusedByteBits;

  assign reqTag   = fetchAddr[ADDR_W-1 -: TAG_W];
  assign reqIndex = fetchAddr[LINE_LO +: INDEX_W];
  assign reqWord  = fetchAddr[LINE_LO-1 -: OFFS_W];
  assign unusedByteBits = ^fetchAddr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      curIndex  <= '0;
      curTag    <= '0;
      curValid  <= 1'b0;
      fillTag   <= '0;
      offsetCnt <= '0;
      beatCnt   <= '0;
      wordValid <= '0;
      sweepCnt  <= '0;
      lineValid <= '0;
    end else begin
      if (ctrl.loadLine) begin
        curIndex <= reqIndex;
        curTag   <= tagRam[reqIndex];
        curValid <= lineValid[reqIndex];
      end
      if (ctrl.startFill) begin
        fillTag             <= reqTag;
        offsetCnt           <= reqWord;
        beatCnt             <= '0;
        wordValid           <= '0;
        curValid            <= 1'b0;
        lineValid[curIndex] <= 1'b0;
      end
      if (ctrl.beatAck) begin
        wordValid[offsetCnt] <= 1'b1;
        offsetCnt            <= offsetCnt + 1'b1;  // wraps within the line
        beatCnt              <= beatCnt + 1'b1;
        if (lastBeat) begin
          lineValid[curIndex] <= 1'b1;
          curTag              <= fillTag;
          curValid            <= 1'b1;
        end
      end
      if (ctrl.sweepStep) begin
        lineValid[sweepCnt] <= 1'b0;
        sweepCnt            <= sweepCnt + 1'b1;
      end
      if (ctrl.sweepEnd) curValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.beatAck) dataRam[{curIndex, offsetCnt}] <= wbDatIn;
    if (ctrl.beatAck && lastBeat) tagRam[curIndex] <= fillTag;
  end

  assign lineSame      = (reqIndex == curIndex);
  assign lineHit       = curValid && (curTag == reqTag);
  assign fillLine      = lineSame && (reqTag == fillTag);
  assign fillWordValid = wordValid[reqWord];
  assign ackWord       = (reqWord == offsetCnt);
  assign lastBeat      = &beatCnt;
  assign sweepLast     = &sweepCnt;

  assign fetchData = ctrl.useBypass ? wbDatIn : dataRam[{reqIndex, reqWord}];
  assign wbAdr     = {fillTag, curIndex, offsetCnt, 2'b00};
  assign wbCti     = lastBeat ? CTI_END : CTI_INCR;
endmodule

// File: rtl/icache_ctrl.sv
`timescale 1ns/1ps
module icache_ctrl
  import icache_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          fetchReq,
  input  logic          flushReq,
  input  logic          wbAck,
  input  logic          lineSame,
  input  logic          lineHit,
  input  logic          fillLine,
  input  logic          fillWordValid,
  input  logic          ackWord,
  input  logic          lastBeat,
  input  logic          sweepLast,
  output ctrlStrobes_t  ctrl,
  output logic          fetchReady,
  output logic          busActive
);
  cacheState_e state, nextState;
  logic flushPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      flushPend <= 1'b0;
    end else begin
      state     <= nextState;
      flushPend <= flushReq || (flushPend && state != ST_IDLE);
    end
  end

  always_comb begin
    ctrl       = '0;
    fetchReady = 1'b0;
    nextState  = state;
    unique case (state)
      ST_IDLE: begin
        if (flushPend) begin
          nextState = ST_SWEEP;
        end else if (fetchReq) begin
          if (!lineSame) begin
            ctrl.loadLine = 1'b1;
          end else if (lineHit) begin
            fetchReady = 1'b1;
          end else begin
            ctrl.startFill = 1'b1;
            nextState      = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        ctrl.beatAck = wbAck;
        if (fetchReq && fillLine) begin
          if (fillWordValid) begin
            fetchReady = 1'b1;
          end else if (wbAck && ackWord) begin
            fetchReady     = 1'b1;
            ctrl.useBypass = 1'b1;
          end
        end
        if (wbAck && lastBeat) nextState = ST_IDLE;
      end
      ST_SWEEP: begin
        ctrl.sweepStep = 1'b1;
        if (sweepLast) begin
          ctrl.sweepEnd = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busActive = (state == ST_FILL);
endmodule

// File: rtl/fetch_icache.sv
`timescale 1ns/1ps
module fetch_icache
  import icache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [31:0]       fetchData,
  input  logic              flushReq,
  output logic              wbCyc,
  output logic              wbStb,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [2:0]        wbCti,
  output logic [1:0]        wbBte,
  input  logic              wbAck,
  input  logic [31:0]       wbDatIn
);
  ctrlStrobes_t ctrl;
  logic lineSame, lineHit, fillLine, fillWordValid, ackWord, lastBeat, sweepLast;
  logic busActive;

  icache_ctrl uCtrl (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .flushReq(flushReq), .wbAck(wbAck),
    .lineSame(lineSame), .lineHit(lineHit), .fillLine(fillLine),
    .fillWordValid(fillWordValid), .ackWord(ackWord), .lastBeat(lastBeat),
    .sweepLast(sweepLast), .ctrl(ctrl), .fetchReady(fetchReady), .busActive(busActive)
  );

  icache_datapath #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .fetchAddr(fetchAddr), .wbDatIn(wbDatIn),
    .lineSame(lineSame), .lineHit(lineHit), .fillLine(fillLine),
    .fillWordValid(fillWordValid), .ackWord(ackWord), .lastBeat(lastBeat),
    .sweepLast(sweepLast), .fetchData(fetchData), .wbAdr(wbAdr), .wbCti(wbCti)
  );

  assign wbCyc = busActive;
  assign wbStb = busActive;
  assign wbBte = BTE_WRAP8;
endmodule

// File: rtl/icache_checker.sv
`timescale 1ns/1ps
module icache_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchReady,
  input logic              wbCyc,
  input logic              wbStb,
  input logic [ADDR_W-1:0] wbAdr,
  input logic [2:0]        wbCti,
  input logic [1:0]        wbBte,
  input logic              wbAck
);
  logic [2:0] beatSeen;
  always_ff @(posedge clk) begin
    if (rst) beatSeen <= '0;
    else if (wbCyc && wbAck) beatSeen <= beatSeen + 1'b1;
  end

  a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (rst)
    fetchReady |-> fetchReq);

  a_r3_stb_with_cyc: assert property (@(posedge clk) disable iff (rst)
    wbStb == wbCyc);

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    wbCyc && !wbAck |=> wbCyc && $stable(wbAdr));

  a_r3_wrap_step: assert property (@(posedge clk) disable iff (rst)
    wbCyc && wbAck && wbCti != 3'b111 |=>
      wbCyc && wbAdr[4:2] == $past(wbAdr[4:2]) + 3'd1 &&
      wbAdr[ADDR_W-1:5] == $past(wbAdr[ADDR_W-1:5]));

  a_r3_start_at_miss: assert property (@(posedge clk) disable iff (rst)
    $rose(wbCyc) |-> $past(fetchReq) && wbAdr[ADDR_W-1:2] == $past(fetchAddr[ADDR_W-1:2]));

  a_r4_eight_beats: assert property (@(posedge clk) disable iff (rst)
    wbCyc && wbAck && wbCti == 3'b111 |-> beatSeen == 3'd7);

  a_r4_incr_code: assert property (@(posedge clk) disable iff (rst)
    wbCyc && beatSeen != 3'd7 |-> wbCti == 3'b010 && wbBte == 2'b10);

  a_r4_burst_ends: assert property (@(posedge clk) disable iff (rst)
    wbCyc && wbAck && wbCti == 3'b111 |=> !wbCyc);

  a_r7_fill_line_only: assert property (@(posedge clk) disable iff (rst)
    wbCyc && fetchReady |-> fetchAddr[ADDR_W-1:5] == wbAdr[ADDR_W-1:5]);
endmodule

bind fetch_icache icache_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst(rst), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
  .fetchReady(fetchReady), .wbCyc(wbCyc), .wbStb(wbStb), .wbAdr(wbAdr),
  .wbCti(wbCti), .wbBte(wbBte), .wbAck(wbAck)
);

// File: tb/fetch_icache_test.sv
`timescale 1ns/1ps
module fetch_icache_test;
  localparam int LINES = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady;
  logic [31:0] fetchData;
  logic        flushReq = 1'b0;
  logic        wbCyc, wbStb;
  logic [31:0] wbAdr;
  logic [2:0]  wbCti;
  logic [1:0]  wbBte;
  logic        wbAck = 1'b0;
  logic [31:0] wbDatIn = '0;

  int checks = 0;
  int failures = 0;
  int ackPct = 100;
  int burstBeat = 0;
  int cycleCount = 0;
  logic [31:0] lineBase = '0;
  logic [2:0]  startWord = '0;
  logic [31:0] lastBurstStart = '0;

  fetch_icache uut (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchData(fetchData), .flushReq(flushReq),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbAdr(wbAdr), .wbCti(wbCti), .wbBte(wbBte),
    .wbAck(wbAck), .wbDatIn(wbDatIn)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      failures++;
      $display("FAIL R10 watchdog actual=%0d expected<=150000", cycleCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E3779B1) ^ {w[15:0], w[31:16]} ^ 32'h5EED1234;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge once inputs are set.
  task automatic driveAndObserve();
    logic [31:0] expAdr;
    wbAck   = wbCyc && wbStb && (int'($urandom_range(99, 0)) < ackPct);
    wbDatIn = wbAck ? memWord(wbAdr) : 32'hDEADBEEF;
    #1;
    if (wbAck) begin
      if (burstBeat == 0) begin
        lineBase       = {wbAdr[31:5], 5'b0};
        startWord      = wbAdr[4:2];
        lastBurstStart = wbAdr;
      end
      expAdr = lineBase;
      expAdr[4:2] = startWord + 3'(burstBeat);
      check("R3 burst address order", wbAdr, expAdr);
      check("R4 cti code", {29'b0, wbCti}, (burstBeat == 7) ? 32'd7 : 32'd2);
      check("R4 bte code", {30'b0, wbBte}, 32'd2);
      burstBeat = (burstBeat + 1) % 8;
    end
    if (fetchReady && wbCyc && fetchAddr[31:5] != wbAdr[31:5]) begin
      checks++;
      failures++;
      $display("FAIL R7 ready during refill of other line actual=%h expected=%h",
               fetchAddr[31:5], wbAdr[31:5]);
    end
  endtask

  task automatic doFetch(input logic [31:0] a, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      fetchReq = 1'b1; fetchAddr = a; flushReq = 1'b0;
      driveAndObserve();
      cyc++;
    end while (!fetchReady);
    check("R1 R5 fetch data", fetchData, memWord(a));
  endtask

  task automatic tryFetch(input logic [31:0] a, input int n, output int readies);
    readies = 0;
    repeat (n) begin
      @(negedge clk);
      fetchReq = 1'b1; fetchAddr = a; flushReq = 1'b0;
      driveAndObserve();
      if (fetchReady) readies++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      fetchReq = 1'b0; flushReq = 1'b0;
      driveAndObserve();
    end
  endtask

  task automatic pulseFlush();
    @(negedge clk);
    fetchReq = 1'b0; flushReq = 1'b1;
    driveAndObserve();
  endtask

  initial begin
    int c;
    int r;
    logic [31:0] a;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    #1;
    check("R10 no bus in reset", {31'b0, wbCyc}, 32'd0);
    check("R10 no ready in reset", {31'b0, fetchReady}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    check("R10 no bus after reset", {30'b0, wbCyc, wbStb}, 32'd0);

    // Critical word first after reset (index 0 is the current index)
    ackPct = 100;
    doFetch(32'h10, c);
    check("R5 miss returns with first ack", 32'(c), 32'd2);
    check("R3 burst starts at missed word", lastBurstStart, 32'h10);
    doFetch(32'h14, c);
    check("R6 word arriving now", 32'(c), 32'd1);
    doFetch(32'h10, c);
    check("R6 word already arrived", 32'(c), 32'd1);
    doFetch(32'h00, c);
    check("R6 stall for later word", 32'(c), 32'd2);
    idle(10);
    doFetch(32'h1C, c);
    check("R8 full line hit", 32'(c), 32'd1);
    check("R8 no bus on hit", {31'b0, wbCyc}, 32'd0);
    doFetch(32'h08, c);
    check("R8 full line hit word 2", 32'(c), 32'd1);

    // Line change penalty
    doFetch(32'h20, c);
    check("R2 miss on new index", 32'(c), 32'd3);
    idle(10);
    doFetch(32'h04, c);
    check("R2 line change hit", 32'(c), 32'd2);
    doFetch(32'h0C, c);
    check("R1 same line hit", 32'(c), 32'd1);

    // Aliasing tags share index 0
    doFetch(32'h800, c);
    check("R11 alias miss", 32'(c), 32'd2);
    idle(10);
    doFetch(32'h00, c);
    check("R11 evicted line misses", 32'(c), 32'd2);
    doFetch(32'h03, c);
    check("R11 byte bits ignored", 32'(c), 32'd1);
    idle(10);

    // Refill held without acknowledges
    ackPct = 0;
    tryFetch(32'h40, 5, r);
    check("R5 no data before ack", 32'(r), 32'd0);
    tryFetch(32'h48, 4, r);
    check("R6 missing word stalls", 32'(r), 32'd0);
    tryFetch(32'h00, 4, r);
    check("R7 other line stalls", 32'(r), 32'd0);
    ackPct = 100;
    doFetch(32'h00, c);
    check("R7 other line after burst", 32'(c), 32'd10);
    idle(10);

    // Invalidate sweep
    pulseFlush();
    doFetch(32'h00, c);
    check("R9 sweep stall then miss", 32'(c), 32'(LINES + 3));
    check("R9 refetch burst start", lastBurstStart, 32'h00);
    idle(10);

    // Random traffic
    ackPct = 60;
    a = '0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99, 0) < 50) a = (a + 32'd4) & 32'h1FFF;
      else a = {19'b0, 13'($urandom)};
      if ($urandom_range(199, 0) == 0) pulseFlush();
      if ($urandom_range(99, 0) < 10) idle(int'($urandom_range(3, 1)));
      doFetch(a, c);
    end
    idle(12);
    check("R4 bursts complete", 32'(burstBeat), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule